// File: doc/BRIEF.md
# Two-Pin Serial Debug Probe

This block makes a wide internal status word visible on an oscilloscope using only two spare output pins. A frame has a fixed number of slots, and that number is a power of two larger than the word. The data pin carries one bit of the word in each slot. The marker pin is high for the whole of the first slot, so the scope can trigger on it. A slot lasts a fixed number of system clock cycles, set by a divider parameter. For example, a divider of 50 on a 50 MHz clock gives 1 µs slots. All logic runs in the single system clock domain.

The word is copied into a shadow register when a frame starts, so every bit of one frame belongs to the same sample. A mode input selects between two behaviours. In free-running mode, frames follow one another with no gap. In single-shot mode, each change of the watched word requests one frame. A request that arrives during a frame is held, and it starts a new frame directly after the last slot. Slots beyond the word width are sent low as padding.

Top module: `dbg_probe_ser`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it, both `ser_data` and `ser_mark` are low.
- R2: Every slot lasts exactly `CLK_DIV` system clock cycles, so `ser_mark` stays high for exactly `CLK_DIV` cycles per frame.
- R3: With the default bit order, slot k (for k below `WORD_W`) carries bit k of the latched word on `ser_data`, starting with bit 0 in slot 0.
- R4: `ser_mark` is high only during slot 0 of each frame.
- R5: In slots `WORD_W` through 2^`SLOT_W`-1, `ser_data` is low.
- R6: When `mode_free` is 0 (single-shot) and `watch_word` does not change, no frame is sent.
- R7: In single-shot mode, a change of `watch_word` starts a frame at the next slot boundary, so `ser_mark` rises within `CLK_DIV` cycles.
- R8: The word is latched when a frame starts. A change of `watch_word` during a frame does not affect that frame.
- R9: In single-shot mode, a change made during a frame starts the next frame immediately after the last slot, carrying the new word.
- R10: A change that occurs in the same cycle as a frame launch is taken in by that launch. That frame carries the newest word, and no further frame follows.
- R11: When `mode_free` is 1, frames follow one another back to back with no idle slot, even when the word does not change.
- R12: Raising `rst` in the middle of a frame drives both pins low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_free | input | 1 | 1 = free-running frames, 0 = one frame per word change |
| watch_word | input | WORD_W | Status word to be observed |
| ser_data | output | 1 | Serial data pin, one word bit per slot |
| ser_mark | output | 1 | Frame marker pin, high during slot 0 |

## Verification
Three events can coincide in one cycle: the end of slot 31 of a frame, a pending request left over from an earlier change, and a new change of the watched word. To provoke this, the bench changes the word once in the middle of a frame and then again exactly one cycle before the final slot boundary, timing both changes from the observed rise of the marker. It then checks three things. The next frame must start back to back. It must carry the second new word rather than the first. No extra frame may follow.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

   typedef enum logic {
      RUN_SINGLE = 1'b0,
      RUN_FREE   = 1'b1
   } run_mode_e;

   typedef enum logic {
      ORDER_LSB = 1'b0,
      ORDER_MSB = 1'b1
   } bit_order_e;

endpackage

// File: rtl/dbgp_tick.sv
module dbgp_tick #(
   parameter int DIV = 50
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] TOP = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)
               cnt_q <= '0;
            else if (cnt_q == TOP)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == TOP);

         // R2: a slot boundary never repeats in consecutive cycles
         p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/dbgp_watch.sv
module dbgp_watch #(
   parameter int W = 30
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] word,
   output logic         req
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst)
         prev_q <= '0;
      else
         prev_q <= word;
   end

   assign req = (word != prev_q);

endmodule

// File: rtl/dbgp_seq.sv
module dbgp_seq
   import dbgp_pkg::*;
#(
   parameter int W  = 30,
   parameter int SW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  run_mode_e     mode,
   input  logic          req,
   input  logic [W-1:0]  word,
   output logic          active_q,
   output logic [SW-1:0] slot_q,
   output logic [W-1:0]  shadow_q,
   output logic          active_d,
   output logic [SW-1:0] slot_d,
   output logic [W-1:0]  shadow_d,
   output logic          launch
);

   localparam logic [SW-1:0] LAST = '1;

   logic pend_q, pend_d;
   logic want;
   logic at_end;

   assign want   = (mode == RUN_FREE) | pend_q | req;
   assign at_end = active_q & (slot_q == LAST);
   assign launch = tick & want & (~active_q | at_end);

   always_comb begin
      active_d = active_q;
      slot_d   = slot_q;
      shadow_d = shadow_q;
      if (launch) begin
         active_d = 1'b1;
         slot_d   = '0;
         shadow_d = word;
      end else if (tick && active_q) begin
         if (at_end)
            active_d = 1'b0;
         else
            slot_d = slot_q + 1'b1;
      end
   end

   assign pend_d = launch ? 1'b0 : (pend_q | req);

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         slot_q   <= '0;
         shadow_q <= '0;
         pend_q   <= 1'b0;
      end else begin
         active_q <= active_d;
         slot_q   <= slot_d;
         shadow_q <= shadow_d;
         pend_q   <= pend_d;
      end
   end

   // R2: the slot index moves only on a divider tick
   p_slot_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(slot_q));

   // R8: the latched word is frozen between slot boundaries
   p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(shadow_q));

   // R6: single-shot frames need a pending or fresh change
   p_single_launch_r6: assert property (@(posedge clk) disable iff (rst)
      (launch && mode == RUN_SINGLE) |-> (pend_q || req));

endmodule

// File: rtl/dbgp_pins.sv
module dbgp_pins
   import dbgp_pkg::*;
#(
   parameter int         W     = 30,
   parameter int         SW    = 5,
   parameter bit_order_e ORDER = ORDER_LSB
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          active_d,
   input  logic [SW-1:0] slot_d,
   input  logic [W-1:0]  shadow_d,
   output logic          ser_data,
   output logic          ser_mark
);

   logic [SW-1:0] sel;
   logic          in_word;
   logic          data_d, mark_d;

   generate
      if (ORDER == ORDER_LSB) begin : g_lsb
         assign sel = slot_d;
      end else begin : g_msb
         assign sel = SW'(W - 1) - slot_d;
      end
   endgenerate

   assign in_word = (int'(slot_d) < W);
   assign data_d  = active_d & in_word & shadow_d[sel];
   assign mark_d  = active_d & (slot_d == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         ser_data <= 1'b0;
         ser_mark <= 1'b0;
      end else begin
         ser_data <= data_d;
         ser_mark <= mark_d;
      end
   end

   // R1, R12: reset silences both pins on the following edge
   p_rst_quiet_r1: assert property (@(posedge clk)
      rst |=> (!ser_data && !ser_mark));

endmodule

// File: rtl/dbg_probe_ser.sv
module dbg_probe_ser
   import dbgp_pkg::*;
#(
   parameter int         WORD_W  = 30,
   parameter int         SLOT_W  = 5,
   parameter int         CLK_DIV = 50,
   parameter bit_order_e ORDER   = ORDER_LSB
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_free,
   input  logic [WORD_W-1:0] watch_word,
   output logic              ser_data,
   output logic              ser_mark
);

   localparam int NSLOT = 1 << SLOT_W;

   generate
      if (WORD_W < 1 || WORD_W > NSLOT) begin : g_bad_width
         $error("WORD_W must lie between 1 and the slot count");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
   endgenerate

   run_mode_e            mode;
   logic                 tick;
   logic                 req;
   logic                 launch;
   logic                 active_q, active_d;
   logic [SLOT_W-1:0]    slot_q, slot_d;
   logic [WORD_W-1:0]    shadow_q, shadow_d;

   assign mode = run_mode_e'(mode_free);

   dbgp_tick #(.DIV(CLK_DIV)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   dbgp_watch #(.W(WORD_W)) u_watch (
      .clk  (clk),
      .rst  (rst),
      .word (watch_word),
      .req  (req)
   );

   dbgp_seq #(.W(WORD_W), .SW(SLOT_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .mode     (mode),
      .req      (req),
      .word     (watch_word),
      .active_q (active_q),
      .slot_q   (slot_q),
      .shadow_q (shadow_q),
      .active_d (active_d),
      .slot_d   (slot_d),
      .shadow_d (shadow_d),
      .launch   (launch)
   );

   dbgp_pins #(.W(WORD_W), .SW(SLOT_W), .ORDER(ORDER)) u_pins (
      .clk      (clk),
      .rst      (rst),
      .active_d (active_d),
      .slot_d   (slot_d),
      .shadow_d (shadow_d),
      .ser_data (ser_data),
      .ser_mark (ser_mark)
   );

   // R4: the marker pin agrees with the sequencer being in slot 0
   p_mark_slot0_r4: assert property (@(posedge clk) disable iff (rst)
      ser_mark |-> (active_q && slot_q == '0));

   // R5: padding slots beyond the word keep the data pin low
   p_pad_low_r5: assert property (@(posedge clk) disable iff (rst)
      (active_q && int'(slot_q) >= WORD_W) |-> !ser_data);

   // R11: free-running mode never leaves the frame sequence
   p_free_busy_r11: assert property (@(posedge clk) disable iff (rst)
      (active_q && mode == RUN_FREE) |=> active_q);

endmodule

// File: tb/test_dbg_probe_ser.sv
module test_dbg_probe_ser;

   localparam int W  = 30;
   localparam int SW = 5;
   localparam int NS = 1 << SW;
   localparam int DV = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         mode_free = 1'b0;
   logic [W-1:0] word = '0;
   logic         ser_data, ser_mark;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dbg_probe_ser #(.WORD_W(W), .SLOT_W(SW), .CLK_DIV(DV)) i_dbg_probe_ser (
      .clk        (clk),
      .rst        (rst),
      .mode_free  (mode_free),
      .watch_word (word),
      .ser_data   (ser_data),
      .ser_mark   (ser_mark)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_mark(input int limit, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (ser_mark) begin
            seen = 1'b1;
            break;
         end
      end
   endtask

   task automatic count_marks(input int cycles, output int n);
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (ser_mark) n++;
      end
   endtask

   // Samples one frame mid-slot; ends one cycle into the following slot 0.
   task automatic capture(input logic [W-1:0] exp, input bit synced,
                          input bit exp_next, input string req);
      bit seen;
      if (!synced) begin
         wait_mark(40 * NS * DV, seen);
         chk("R4", {req, " frame start seen"}, 32'(seen), 32'd1);
         @(negedge clk);
      end
      for (int k = 0; k < NS; k++) begin
         if (k < W)
            chk("R3", {req, " data bit"}, 32'(ser_data), 32'(exp[k]));
         else
            chk("R5", {req, " pad slot low"}, 32'(ser_data), 32'd0);
         chk("R4", {req, " marker"}, 32'(ser_mark), 32'(k == 0));
         repeat (DV) @(negedge clk);
      end
      chk(req, "next frame back to back", 32'(ser_mark), 32'(exp_next));
   endtask

   task automatic t_reset();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R1", "pins low in reset", {30'd0, ser_data, ser_mark}, 32'd0);
      end
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "pins low after reset", {30'd0, ser_data, ser_mark}, 32'd0);
   endtask

   task automatic t_idle();
      int n;
      count_marks(3 * NS * DV, n);
      chk("R6", "no frame without change", 32'(n), 32'd0);
   endtask

   task automatic t_launch();
      bit seen;
      int n;
      word = 30'h0123_4567;
      wait_mark(DV, seen);
      chk("R7", "frame starts within one slot", 32'(seen), 32'd1);
      @(negedge clk);
      capture(30'h0123_4567, 1'b1, 1'b0, "R7");
      count_marks(2 * NS * DV, n);
      chk("R6", "single frame only", 32'(n), 32'd0);
   endtask

   task automatic t_mark_width();
      bit seen;
      int w;
      word = 30'h3FFF_0000;
      wait_mark(2 * DV, seen);
      w = 0;
      while (ser_mark && w < 10 * DV) begin
         w++;
         @(negedge clk);
      end
      chk("R2", "marker width in cycles", 32'(w), 32'(DV));
      repeat (NS * DV) @(negedge clk);
   endtask

   task automatic t_pending();
      word = 30'h2AAA_AAAA;
      fork
         capture(30'h2AAA_AAAA, 1'b0, 1'b1, "R9");
         begin
            do @(negedge clk); while (!ser_mark);
            repeat (10 * DV) @(negedge clk);
            word = 30'h1555_5555;   // R8: mid-frame change
         end
      join
      capture(30'h1555_5555, 1'b1, 1'b0, "R9");
   endtask

   task automatic t_same_cycle();
      int n;
      repeat (NS * DV) @(negedge clk);
      word = 30'h0F0F_0F0F;
      fork
         capture(30'h0F0F_0F0F, 1'b0, 1'b1, "R10");
         begin
            do @(negedge clk); while (!ser_mark);
            repeat (10 * DV) @(negedge clk);
            word = 30'h3333_3333;
            repeat (NS * DV - 1 - 10 * DV) @(negedge clk);
            word = 30'h0000_1234;   // lands in the launch cycle
         end
      join
      capture(30'h0000_1234, 1'b1, 1'b0, "R10");
      count_marks(2 * NS * DV, n);
      chk("R10", "no extra frame after absorbed change", 32'(n), 32'd0);
   endtask

   task automatic t_free();
      mode_free = 1'b1;
      capture(30'h0000_1234, 1'b0, 1'b1, "R11");
      fork
         capture(30'h0000_1234, 1'b1, 1'b1, "R8");
         begin
            repeat (5 * DV) @(negedge clk);
            word = 30'h3C3C_3C3C;
         end
      join
      capture(30'h3C3C_3C3C, 1'b1, 1'b1, "R11");
   endtask

   task automatic t_reset_mid();
      chk("R12", "marker high before reset", 32'(ser_mark), 32'd1);
      rst = 1'b1;
      @(negedge clk);
      chk("R12", "pins low after mid-frame reset",
          {30'd0, ser_data, ser_mark}, 32'd0);
      rst = 1'b0;
      mode_free = 1'b0;
   endtask

   initial begin
      t_reset();
      t_idle();
      t_launch();
      t_mark_width();
      t_pending();
      t_same_cycle();
      t_free();
      t_reset_mid();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule